// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block gathers eight event sources into one interrupt line for a microprocessor. Three transmit-frame and three receive-frame channel events, plus one transmit-error and one receive-error event, arrive as single-cycle pulses. Each pulse sets its own bit in a pending-request register, which software can read back. A mask register decides which pending bits may pull the shared interrupt line low. A clear register releases pending bits one at a time.

The interrupt line is open-drain and active low. The block therefore drives a constant low data value and raises an output enable only while at least one unmasked request is pending. Otherwise the pad floats and an external pull-up holds it high.

Three further write-only addresses do not store anything. A write to one of them produces a one-clock strobe for a neighbouring unit: a bit-error meter (reset it and start a measurement), a pseudo-random pattern generator, or the receiver.

Top module: `intreq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the mask register holds all ones, the request register holds zero, `irq_oe_o` is 0 and all three strobes are 0.
- R2: An event pulse sets its request bit on the next clock edge. The bit positions are: bit 7 receive error, bit 6 transmit error, bits 5..3 receive-frame channels 3..1, bits 2..0 transmit-frame channels 3..1. Bits 2..0 map to `tx_frame_evt_i[2:0]` and bits 5..3 map to `rx_frame_evt_i[2:0]`.
- R3: A write to address 0xEB loads the mask. A mask bit of 1 keeps that source off the interrupt line. The source is still recorded in the request register.
- R4: `irq_oe_o` is 1 exactly when some request bit is set and its mask bit is 0. `irq_n_o` is always 0.
- R5: A write to address 0xEC clears every request bit whose data bit is 0. Request bits whose data bit is 1 are unchanged.
- R6: When an event and a clear of the same bit occur in the same cycle, the bit ends up set.
- R7: A write to 0xEF, 0xF0 or 0xF1 pulses `ber_restart_o`, `prbs_reset_o` or `rcv_reset_o` for one cycle, in the cycle after the write edge. The data byte is ignored, and at most one strobe is high at a time.
- R8: While `bus_addr_i` is 0xE9, `bus_rdata_o` shows the request register. Reading does not change it. At any other address `bus_rdata_o` is 0.
- R9: Writes to addresses other than 0xEB and 0xEC leave the mask and the request register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write qualifier for the current cycle |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (request register at 0xE9, otherwise 0) |
| tx_frame_evt_i | input | 3 | Transmit-frame event pulses, channels 3..1 |
| rx_frame_evt_i | input | 3 | Receive-frame event pulses, channels 3..1 |
| tx_err_evt_i | input | 1 | Transmit-error event pulse |
| rx_err_evt_i | input | 1 | Receive-error event pulse |
| irq_n_o | output | 1 | Interrupt data value, always low |
| irq_oe_o | output | 1 | Interrupt output enable (pad drives low when 1) |
| ber_restart_o | output | 1 | Bit-error meter restart strobe |
| prbs_reset_o | output | 1 | Pattern generator reset strobe |
| rcv_reset_o | output | 1 | Receiver reset strobe |

## Verification
Directed phases come first:
- All eight sources fire at once under the reset mask. This separates "latched" from "signalled".
- Partial clear patterns such as 0xF0 show whether zero bits and one bits are handled correctly.
- A clear of every bit lands on the same cycle as a fresh event, which shows which of the two wins.
- Writes go to the strobe addresses back to back and with arbitrary data.
- Writes go to unused addresses.

A long random phase then mixes event bursts with mask changes, clear writes, strobe writes and reads. This exposes any wrong bit position in the mask and clear paths, and any interaction between them and the enable output.

// File: rtl/intreq_pkg.sv
package intreq_pkg;
  localparam int NCH  = 3;
  localparam int NSRC = 2 * NCH + 2;
  localparam int AW   = 8;

  typedef logic [NSRC-1:0] src_vec_t;
  typedef logic [AW-1:0]   addr_t;

  localparam addr_t A_REQ  = 8'hE9;
  localparam addr_t A_MASK = 8'hEB;
  localparam addr_t A_CLR  = 8'hEC;
  localparam addr_t A_BER  = 8'hEF;
  localparam addr_t A_PRBS = 8'hF0;
  localparam addr_t A_RCV  = 8'hF1;

  typedef struct packed {
    logic ber;
    logic prbs;
    logic rcv;
  } strobe_t;
endpackage

// File: rtl/intreq_rst_sync.sv
module intreq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/intreq_decode.sv
module intreq_decode
  import intreq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  addr_t    addr_i,
  input  src_vec_t wdata_i,
  input  src_vec_t req_i,
  output logic     mask_we_o,
  output src_vec_t clr_o,
  output src_vec_t rdata_o,
  output strobe_t  strobe_o
);
  strobe_t strobe_d, strobe_q;

  always_comb begin
    mask_we_o     = wr_i && (addr_i == A_MASK);
    clr_o         = (wr_i && (addr_i == A_CLR)) ? ~wdata_i : '0;
    rdata_o       = (addr_i == A_REQ) ? req_i : '0;
    strobe_d.ber  = wr_i && (addr_i == A_BER);
    strobe_d.prbs = wr_i && (addr_i == A_PRBS);
    strobe_d.rcv  = wr_i && (addr_i == A_RCV);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= '0;
    else         strobe_q <= strobe_d;
  end

  assign strobe_o = strobe_q;

  // R7: strobes never overlap
  a_r7_strobe_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_q));
endmodule

// File: rtl/intreq_core.sv
module intreq_core
  import intreq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  logic     mask_we_i,
  input  src_vec_t mask_wdata_i,
  input  src_vec_t clr_i,
  output src_vec_t req_o,
  output logic     irq_oe_o
);
  src_vec_t req_d, req_q;
  src_vec_t mask_d, mask_q;

  // next-state: a set by an event overrides a same-cycle clear
  always_comb begin
    req_d  = (req_q & ~clr_i) | evt_i;
    mask_d = mask_q;
    if (mask_we_i) mask_d = mask_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      mask_q <= '1;
    end else begin
      req_q  <= req_d;
      mask_q <= mask_d;
    end
  end

  assign req_o    = req_q;
  assign irq_oe_o = |(req_q & ~mask_q);

  // R2 / R6: every pulsed source is pending on the next cycle
  a_r2_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((req_q & $past(evt_i)) == $past(evt_i)));

  // R5: cleared bits without a concurrent event are gone on the next cycle
  a_r5_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~evt_i)) |=> ((req_q & $past(clr_i & ~evt_i)) == '0));

  // R9: the mask only moves on a mask write
  a_r9_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_q));
endmodule

// File: rtl/intreq_ctrl.sv
module intreq_ctrl
  import intreq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_wr_i,
  input  logic [7:0]    bus_addr_i,
  input  logic [7:0]    bus_wdata_i,
  output logic [7:0]    bus_rdata_o,
  input  logic [2:0]    tx_frame_evt_i,
  input  logic [2:0]    rx_frame_evt_i,
  input  logic          tx_err_evt_i,
  input  logic          rx_err_evt_i,
  output logic          irq_n_o,
  output logic          irq_oe_o,
  output logic          ber_restart_o,
  output logic          prbs_reset_o,
  output logic          rcv_reset_o
);
  logic     rst_int_n;
  src_vec_t evt, req, clr;
  logic     mask_we;
  strobe_t  strobe;

  assign evt = {rx_err_evt_i, tx_err_evt_i, rx_frame_evt_i, tx_frame_evt_i};

  intreq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_int_n)
  );

  intreq_decode u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .req_i     (req),
    .mask_we_o (mask_we),
    .clr_o     (clr),
    .rdata_o   (bus_rdata_o),
    .strobe_o  (strobe)
  );

  intreq_core u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_int_n),
    .evt_i        (evt),
    .mask_we_i    (mask_we),
    .mask_wdata_i (bus_wdata_i),
    .clr_i        (clr),
    .req_o        (req),
    .irq_oe_o     (irq_oe_o)
  );

  assign irq_n_o       = 1'b0;
  assign ber_restart_o = strobe.ber;
  assign prbs_reset_o  = strobe.prbs;
  assign rcv_reset_o   = strobe.rcv;

  // R4: with nothing pending the pad is never driven
  a_r4_quiet_when_empty: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (req == '0) |-> !irq_oe_o);
endmodule

// File: tb/intreq_ctrl_tb.sv
`timescale 1ns/1ps
module intreq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr;
  logic [7:0] addr, wdata, evt;
  logic [7:0] rdata;
  logic       irq_n, irq_oe, s_ber, s_prbs, s_rcv;

  int checks = 0;
  int failures = 0;
  string phase = "R1";
  bit done = 1'b0;

  // reference state
  logic [7:0] m_req, m_mask;
  logic       m_ber, m_prbs, m_rcv;

  always #4 clk = ~clk;

  intreq_ctrl u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .bus_wr_i       (wr),
    .bus_addr_i     (addr),
    .bus_wdata_i    (wdata),
    .bus_rdata_o    (rdata),
    .tx_frame_evt_i (evt[2:0]),
    .rx_frame_evt_i (evt[5:3]),
    .tx_err_evt_i   (evt[6]),
    .rx_err_evt_i   (evt[7]),
    .irq_n_o        (irq_n),
    .irq_oe_o       (irq_oe),
    .ber_restart_o  (s_ber),
    .prbs_reset_o   (s_prbs),
    .rcv_reset_o    (s_rcv)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= 8'h00; m_mask <= 8'hFF;
      m_ber <= 1'b0; m_prbs <= 1'b0; m_rcv <= 1'b0;
    end else begin
      m_req  <= (m_req & ~((wr && addr == 8'hEC) ? ~wdata : 8'h00)) | evt;
      if (wr && addr == 8'hEB) m_mask <= wdata;
      m_ber  <= wr && addr == 8'hEF;
      m_prbs <= wr && addr == 8'hF0;
      m_rcv  <= wr && addr == 8'hF1;
    end
  end

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", rq, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R4", {7'd0, irq_oe}, {7'd0, |(m_req & ~m_mask)});
      chk("R4", {7'd0, irq_n}, 8'h00);
      chk("R8", rdata, (addr == 8'hE9) ? m_req : 8'h00);
      chk("R7", {5'd0, s_ber, s_prbs, s_rcv}, {5'd0, m_ber, m_prbs, m_rcv});
    end
  end

  task automatic drive(input logic w, input logic [7:0] a, input logic [7:0] d, input logic [7:0] e);
    @(posedge clk); #2;
    wr = w; addr = a; wdata = d; evt = e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 8'hE9, 8'h00, 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr = 1'b0; addr = 8'hE9; wdata = 8'h00; evt = 8'h00;
    // R1: reset state observed while reset held
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(5);
    chk("R1", rdata, 8'h00);
    chk("R1", {7'd0, irq_oe}, 8'h00);

    // R3: all sources under reset mask are latched but not signalled
    phase = "R3";
    drive(1'b0, 8'hE9, 8'h00, 8'hFF);
    idle(1);
    @(negedge clk);
    chk("R3", rdata, 8'hFF);
    chk("R3", {7'd0, irq_oe}, 8'h00);

    // R8: repeated reads keep the value, other address reads zero
    phase = "R8";
    idle(3);
    @(negedge clk);
    chk("R8", rdata, 8'hFF);
    drive(1'b0, 8'hEB, 8'h00, 8'h00);
    @(negedge clk);
    chk("R8", rdata, 8'h00);

    // R5: zero bits clear, one bits keep
    phase = "R5";
    drive(1'b1, 8'hEC, 8'hF0, 8'h00);
    idle(1);
    @(negedge clk);
    chk("R5", rdata, 8'hF0);

    // R4: unmask receive error (bit 7)
    phase = "R4";
    drive(1'b1, 8'hEB, 8'h7F, 8'h00);
    idle(1);
    @(negedge clk);
    chk("R4", {7'd0, irq_oe}, 8'h01);
    drive(1'b1, 8'hEB, 8'hFF, 8'h00);
    idle(1);
    @(negedge clk);
    chk("R4", {7'd0, irq_oe}, 8'h00);

    // R6: clear-all while channel 1 transmit event arrives
    phase = "R6";
    drive(1'b1, 8'hEB, 8'h00, 8'h00);
    drive(1'b1, 8'hEC, 8'h00, 8'h01);
    idle(1);
    @(negedge clk);
    chk("R6", rdata, 8'h01);
    chk("R6", {7'd0, irq_oe}, 8'h01);

    // R9: writes elsewhere change nothing
    phase = "R9";
    drive(1'b1, 8'hE9, 8'h00, 8'h00);
    drive(1'b1, 8'hEA, 8'hFF, 8'h00);
    drive(1'b1, 8'hED, 8'h00, 8'h00);
    idle(1);
    @(negedge clk);
    chk("R9", rdata, 8'h01);
    chk("R9", {7'd0, irq_oe}, 8'h01);

    // R7: strobe addresses back to back with arbitrary data
    phase = "R7";
    drive(1'b1, 8'hEF, 8'h5A, 8'h00);
    drive(1'b1, 8'hF0, 8'h00, 8'h00);
    drive(1'b1, 8'hF1, 8'hFF, 8'h00);
    drive(1'b0, 8'hEF, 8'h00, 8'h00);
    idle(2);
    chk("R7", rdata, 8'h01);

    // R2: each source alone, then cleared
    phase = "R2";
    drive(1'b1, 8'hEC, 8'h00, 8'h00);
    for (int b = 0; b < 8; b++) begin
      drive(1'b0, 8'hE9, 8'h00, 8'h01 << b);
      idle(1);
      @(negedge clk);
      chk("R2", rdata, 8'h01 << b);
      drive(1'b1, 8'hEC, ~(8'h01 << b), 8'h00);
    end

    // random mix, checked every cycle against the reference
    phase = "R2 random";
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic [7:0] e;
      case ($urandom_range(0, 7))
        0, 1: a = 8'hE9;
        2:    a = 8'hEB;
        3:    a = 8'hEC;
        4:    a = 8'hEF;
        5:    a = 8'hF0;
        6:    a = 8'hF1;
        default: a = 8'($urandom);
      endcase
      e = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      drive(1'($urandom_range(0, 1)), a, 8'($urandom), e);
    end
    idle(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule